// File: doc/BRIEF.md
# Smartcard Character Transmitter with NACK Retry

This block is the bit-timing core of a serial port running the half-duplex smartcard protocol on one open-drain line. On the transmit side it sends a character made of a low start bit, eight data bits sent least significant first, and an even parity bit. It then releases the line and, exactly 11 elementary time units (etu) after its own start edge, looks for a card pulling the line low to signal a parity error. A low seen there makes it send the same character again. After a set number of retransmissions it gives up and reports a framing error. On the receive side it picks up characters from the card, checks their parity, and pulls the line low itself to refuse a bad one.

All timing runs from a `tick` strobe with sixteen strobes per etu. The card's refusal pulse overlaps the end of the transmitted character. A low edge that shows up near the sample point, or that lasts past the 12 etu guard window, is treated only as a refusal and never as the start of an incoming character. The transmit data interface uses valid/ready. `tx_ready` is high only when both directions are idle. A character is taken on the clock edge where `tx_valid` and `tx_ready` are both high, and `tx_data` must stay stable while `tx_valid` waits. The receive output cannot apply back-pressure: `rx_valid` is a one-cycle pulse with `rx_data`.

Top module: `sc_nack_xmit`

## Requirements
- R1: After reset `line_out` is 1, `tx_ready` is 1, and `tx_done`, `tx_nack`, `frame_err`, `rx_valid` and `rx_perr` are 0.
- R2: An accepted character is driven as 10 bit slots of 16 ticks each: slot 0 low (start), slots 1 to 8 carry data bits 0 to 7, and slot 9 carries the XOR of the 8 data bits (even parity). The line is released from tick 160 after the start edge.
- R3: The transmitter samples `line_in` once, at tick 176 (11.0 etu) after its start edge. The NACK is registered only if the line is low at that sample. A low that begins at tick 165 or at tick 171 (10.68 etu) counts as a NACK. A low that begins at tick 177 has no effect.
- R4: At tick 192 (12 etu) after the start edge, the result is reported. With no NACK, `tx_done` pulses for one cycle. With a NACK, `tx_nack` pulses and the same character is sent again at once, with its new start edge at that point.
- R5: When the character has been sent 1 + MAX_RETRY times (default 3 retries) and every attempt was refused, the last attempt pulses `tx_nack` and `frame_err` together, sends nothing more, and never pulses `tx_done`.
- R6: No incoming start bit is detected while a transmission is in progress. After the block has been busy, the line must be seen high before a new start bit can be detected. A refusal low that lasts past the end of the guard window produces neither `rx_valid` nor `rx_perr`.
- R7: A receive start is detected on a tick where the line is low. Bits are sampled at tick 8 + 16k after detection. A start that has gone high again at tick 8 is dropped with no output.
- R8: A received character with correct even parity gives a one-cycle `rx_valid` pulse with `rx_data`, 192 ticks after detection. A parity error instead gives `rx_perr`, and `line_out` is driven low from tick 168 to tick 183 (10.5 etu for one etu).
- R9: Timing moves forward only on cycles where `tick` is high. With one tick every 3 clocks, a clean character takes 576 clocks (within one tick period) from acceptance to `tx_done`.
- R10: `tx_ready` is 0 while a receive character is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Sub-etu strobe, 16 per etu |
| line_in | input | 1 | Level of the shared line, synchronous to clk |
| line_out | output | 1 | Line drive: 0 pulls low, 1 releases |
| tx_valid | input | 1 | Transmit character offered |
| tx_ready | output | 1 | Block can accept a character |
| tx_data | input | 8 | Character to transmit |
| tx_nack | output | 1 | Pulse: the card refused the current attempt |
| tx_done | output | 1 | Pulse: character accepted by the card |
| frame_err | output | 1 | Pulse: retry budget used up |
| rx_valid | output | 1 | Pulse: received character with good parity |
| rx_data | output | 8 | Received character |
| rx_perr | output | 1 | Pulse: received character had a parity error |

## Verification
The hardest situation to reach is a refusal pulse sitting right against the 11 etu sample point, during the last allowed retry, and lasting beyond the guard window. That is where a wrong NACK decision, an extra retry, or a false receive start would show. The bench models the card as a second open-drain driver, wired-ANDed with `line_out`. It places refusal lows at exact tick offsets from each attempt's start edge, both just before and just after the sample. For the retry case it keeps refusing until the budget runs out and then watches the receive outputs for a long quiet period. Full sweeps over all 256 characters in both directions cover the bit placement and parity.

// File: rtl/sc_nack_pkg.sv
package sc_nack_pkg;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_e;

endpackage

// File: rtl/sc_char_tx.sv
module sc_char_tx
  import sc_nack_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SUB       = 16,
  parameter int MAX_RETRY = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               tick,
  input  logic                               line_in,
  input  logic                               load,
  input  logic [DATA_W-1:0]                  din,
  output logic                               busy,
  output logic                               drive_n,
  output logic                               nack_p,
  output logic                               done_p,
  output logic                               ferr_p,
  output logic [$clog2(MAX_RETRY+2)-1:0]     retries
);

  localparam int FRAME_BITS = DATA_W + 2;
  localparam int TX_END     = FRAME_BITS * SUB;
  localparam int NACK_AT    = (DATA_W + 3) * SUB;
  localparam int GUARD      = (DATA_W + 4) * SUB;
  localparam int CW         = $clog2(GUARD + 1);
  localparam int SH         = $clog2(SUB);
  localparam int FI         = $clog2(FRAME_BITS);
  localparam int RW         = $clog2(MAX_RETRY + 2);

  tx_state_e              st;
  logic [CW-1:0]          cnt;
  logic [DATA_W-1:0]      dat;
  logic                   nack_seen;
  logic [FRAME_BITS-1:0]  frame;
  logic [CW-1:0]          slot;

  always_comb begin
    frame   = {^dat, dat, 1'b0};
    slot    = cnt >> SH;
    drive_n = 1'b1;
    if (st == TX_SEND && cnt < CW'(TX_END)) drive_n = frame[slot[FI-1:0]];
  end

  assign busy = (st == TX_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= TX_IDLE;
      cnt       <= '0;
      dat       <= '0;
      nack_seen <= 1'b0;
      retries   <= '0;
      nack_p    <= 1'b0;
      done_p    <= 1'b0;
      ferr_p    <= 1'b0;
    end else begin
      nack_p <= 1'b0;
      done_p <= 1'b0;
      ferr_p <= 1'b0;
      case (st)
        TX_IDLE: begin
          if (load) begin
            dat       <= din;
            cnt       <= '0;
            retries   <= '0;
            nack_seen <= 1'b0;
            st        <= TX_SEND;
          end
        end
        TX_SEND: begin
          if (tick) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(NACK_AT)) nack_seen <= ~line_in;
            if (cnt == CW'(GUARD - 1)) begin
              cnt       <= '0;
              nack_seen <= 1'b0;
              if (nack_seen) begin
                nack_p <= 1'b1;
                if (retries == RW'(MAX_RETRY)) begin
                  ferr_p <= 1'b1;
                  st     <= TX_IDLE;
                end else begin
                  retries <= retries + 1'b1;
                end
              end else begin
                done_p <= 1'b1;
                st     <= TX_IDLE;
              end
            end
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
  import sc_nack_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SUB    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line_in,
  input  logic              tx_hold,
  output logic              busy,
  output logic              drive_n,
  output logic              valid_p,
  output logic              perr_p,
  output logic [DATA_W-1:0] q
);

  localparam int FRAME_BITS = DATA_W + 2;
  localparam int GUARD      = (DATA_W + 4) * SUB;
  localparam int MID        = SUB / 2;
  localparam int NACK_ON    = FRAME_BITS * SUB + MID;
  localparam int NACK_OFF   = NACK_ON + SUB;
  localparam int CW         = $clog2(GUARD + 1);
  localparam int SH         = $clog2(SUB);

  rx_state_e         st;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     slot;
  logic              mid_pt;
  logic [DATA_W-1:0] sh;
  logic              bad;
  logic              armed;

  always_comb begin
    slot    = cnt >> SH;
    mid_pt  = (cnt[SH-1:0] == SH'(MID));
    drive_n = 1'b1;
    if (st == RX_RUN && bad && cnt >= CW'(NACK_ON) && cnt < CW'(NACK_OFF))
      drive_n = 1'b0;
  end

  assign busy = (st == RX_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RX_IDLE;
      cnt     <= '0;
      sh      <= '0;
      bad     <= 1'b0;
      armed   <= 1'b0;
      q       <= '0;
      valid_p <= 1'b0;
      perr_p  <= 1'b0;
    end else begin
      valid_p <= 1'b0;
      perr_p  <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (tx_hold)      armed <= 1'b0;
          else if (line_in) armed <= 1'b1;
          if (tick && armed && !line_in && !tx_hold) begin
            st    <= RX_RUN;
            cnt   <= CW'(1);
            armed <= 1'b0;
            bad   <= 1'b0;
          end
        end
        RX_RUN: begin
          if (tick) begin
            cnt <= cnt + 1'b1;
            if (mid_pt) begin
              if (slot == '0) begin
                if (line_in) begin
                  st  <= RX_IDLE;
                  cnt <= '0;
                end
              end else if (slot <= CW'(DATA_W)) begin
                sh <= {line_in, sh[DATA_W-1:1]};
              end else if (slot == CW'(DATA_W + 1)) begin
                bad <= line_in ^ (^sh);
              end
            end
            if (cnt == CW'(GUARD - 1)) begin
              st      <= RX_IDLE;
              cnt     <= '0;
              q       <= sh;
              valid_p <= ~bad;
              perr_p  <= bad;
            end
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sc_nack_xmit.sv
module sc_nack_xmit #(
  parameter int DATA_W    = 8,
  parameter int SUB       = 16,
  parameter int MAX_RETRY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line_in,
  output logic              line_out,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_nack,
  output logic              tx_done,
  output logic              frame_err,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_perr
);

  localparam int RW = $clog2(MAX_RETRY + 2);

  logic          tx_busy;
  logic          rx_busy;
  logic          tx_fire;
  logic          tx_hold;
  logic          tx_drive_n;
  logic          rx_drive_n;
  logic [RW-1:0] tx_retries;

  assign tx_ready = ~tx_busy & ~rx_busy;
  assign tx_fire  = tx_valid & tx_ready;
  assign tx_hold  = tx_busy | tx_fire;
  assign line_out = tx_drive_n & rx_drive_n;

  sc_char_tx #(
    .DATA_W   (DATA_W),
    .SUB      (SUB),
    .MAX_RETRY(MAX_RETRY)
  ) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .line_in(line_in),
    .load   (tx_fire),
    .din    (tx_data),
    .busy   (tx_busy),
    .drive_n(tx_drive_n),
    .nack_p (tx_nack),
    .done_p (tx_done),
    .ferr_p (frame_err),
    .retries(tx_retries)
  );

  sc_char_rx #(
    .DATA_W(DATA_W),
    .SUB   (SUB)
  ) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .line_in(line_in),
    .tx_hold(tx_hold),
    .busy   (rx_busy),
    .drive_n(rx_drive_n),
    .valid_p(rx_valid),
    .perr_p (rx_perr),
    .q      (rx_data)
  );

endmodule

// File: rtl/sc_nack_xmit_chk.sv
module sc_nack_xmit_chk #(
  parameter int MAX_RETRY = 3
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           tick,
  input logic                           line_out,
  input logic                           tx_ready,
  input logic                           tx_done,
  input logic                           tx_nack,
  input logic                           frame_err,
  input logic                           rx_valid,
  input logic                           rx_perr,
  input logic                           tx_busy,
  input logic                           rx_busy,
  input logic [$clog2(MAX_RETRY+2)-1:0] tx_retries
);

  p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> line_out);

  p_done_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  p_done_not_ferr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_done && frame_err));

  p_ferr_with_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> tx_nack);

  p_retry_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_retries <= ($clog2(MAX_RETRY+2))'(MAX_RETRY));

  p_no_rx_in_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !rx_busy);

  p_rx_result_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_perr));

  p_hold_without_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tick) |=> $stable(line_out));

  p_busy_rx_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |-> !tx_ready);

endmodule

bind sc_nack_xmit sc_nack_xmit_chk #(.MAX_RETRY(MAX_RETRY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .line_out  (line_out),
  .tx_ready  (tx_ready),
  .tx_done   (tx_done),
  .tx_nack   (tx_nack),
  .frame_err (frame_err),
  .rx_valid  (rx_valid),
  .rx_perr   (rx_perr),
  .tx_busy   (tx_busy),
  .rx_busy   (rx_busy),
  .tx_retries(tx_retries)
);

// File: tb/sim_sc_nack_xmit.sv
`timescale 1ns/1ps
module sim_sc_nack_xmit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       card_n = 1'b1;
  logic       line_in;
  logic       line_out;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = 8'h00;
  logic       tx_nack, tx_done, frame_err, rx_valid, rx_perr;
  logic [7:0] rx_data;

  int cyc = 0;
  int tick_div = 1;
  int n_tests = 0;
  int n_fail = 0;
  int n_rxv = 0, n_rxp = 0;
  bit finished = 0;

  assign line_in = line_out & card_n;

  sc_nack_xmit u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line_in), .line_out(line_out),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_nack(tx_nack), .tx_done(tx_done), .frame_err(frame_err),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    tick <= (tick_div <= 1) ? 1'b1 : ((cyc % tick_div) == 0);
    if (rx_valid) n_rxv <= n_rxv + 1;
    if (rx_perr)  n_rxp <= n_rxp + 1;
  end

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 190000 && !finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: act=%0d exp<190000 cycles", cyc);
      report();
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic at_neg(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic send_tx(input logic [7:0] d, output int a);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    a = cyc;
  endtask

  // card drives a character: start, 8 data LSB first, parity (flipped if bad)
  task automatic card_send(input logic [7:0] d, input bit bad_par, output int c);
    logic [9:0] fr;
    @(negedge clk);
    c  = cyc;
    fr = {(^d) ^ bad_par, d, 1'b0};
    for (int k = 0; k < 10; k++) begin
      at_neg(c + 16*k);
      card_n = fr[k];
    end
    at_neg(c + 160);
    card_n = 1'b1;
  endtask

  initial begin
    int a, c, base_v, base_p, t;
    logic [9:0] fr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 line_out", line_out, 1);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 pulses", {tx_done, tx_nack, frame_err, rx_valid, rx_perr}, 0);

    // R2/R4/R6 sweep of all transmit characters, clean card
    for (int d = 0; d < 256; d++) begin
      send_tx(8'(d), a);
      fr = {^(8'(d)), 8'(d), 1'b0};
      for (int k = 0; k < 10; k++) begin
        at_neg(a + 16*k + 8);
        chk($sformatf("R2 tx %0h slot %0d", d, k), line_out, fr[k]);
      end
      at_neg(a + 165);
      chk("R2 released", line_out, 1);
      at_neg(a + 192);
      chk($sformatf("R4 done %0h", d), {tx_done, tx_nack}, 2'b10);
    end
    at_neg(cyc + 4);
    chk("R6 no rx during tx sweep", n_rxv + n_rxp, 0);

    // R3/R4 NACK starting at tick 171, single refusal then retransmit
    send_tx(8'h5A, a);
    at_neg(a + 171); card_n = 1'b0;
    at_neg(a + 187); card_n = 1'b1;
    at_neg(a + 192);
    chk("R3 nack at 10.68 etu", {tx_done, tx_nack}, 2'b01);
    at_neg(a + 192 + 8);
    chk("R4 resend start", line_out, 0);
    at_neg(a + 192 + 24);
    chk("R4 resend bit0", line_out, 0);
    at_neg(a + 192 + 40);
    chk("R4 resend bit1", line_out, 1);
    at_neg(a + 384);
    chk("R4 done after resend", {tx_done, tx_nack}, 2'b10);

    // R3 early low at 165
    send_tx(8'hC3, a);
    at_neg(a + 165); card_n = 1'b0;
    at_neg(a + 181); card_n = 1'b1;
    at_neg(a + 192);
    chk("R3 nack at 165", tx_nack, 1);
    at_neg(a + 384);
    chk("R3 second attempt ok", tx_done, 1);

    // R3 late low at 177 ignored
    base_v = n_rxv; base_p = n_rxp;
    send_tx(8'h3C, a);
    at_neg(a + 177); card_n = 1'b0;
    at_neg(a + 192);
    chk("R3 late low ignored", {tx_done, tx_nack}, 2'b10);
    at_neg(a + 193); card_n = 1'b1;
    at_neg(a + 450);
    chk("R6 late low not a start", (n_rxv - base_v) + (n_rxp - base_p), 0);

    // R5/R6 every attempt refused, last refusal extends past guard
    base_v = n_rxv; base_p = n_rxp;
    send_tx(8'hA7, a);
    for (int n = 0; n < 4; n++) begin
      at_neg(a + 192*n + 171); card_n = 1'b0;
      at_neg(a + 192*n + 192);
      chk($sformatf("R5 attempt %0d nack", n), tx_nack, 1);
      chk($sformatf("R5 attempt %0d ferr", n), {frame_err, tx_done}, (n == 3) ? 2'b10 : 2'b00);
      at_neg(a + 192*n + 195); card_n = 1'b1;
    end
    at_neg(a + 960);
    chk("R5 no further attempt", line_out, 1);
    at_neg(a + 1100);
    chk("R6 long nack not a start", (n_rxv - base_v) + (n_rxp - base_p), 0);
    chk("R5 ready after ferr", tx_ready, 1);

    // R7/R8/R10 receive sweep, good parity
    for (int d = 0; d < 256; d++) begin
      card_send(8'(d), 1'b0, c);
      at_neg(c + 175);
      chk("R8 no nack on good parity", line_out, 1);
      if (d == 0 || d == 200) chk("R10 busy during rx", tx_ready, 0);
      at_neg(c + 192);
      chk($sformatf("R8 rx %0h flags", d), {rx_valid, rx_perr}, 2'b10);
      chk($sformatf("R7 rx %0h data", d), rx_data, d);
      at_neg(c + 200);
    end

    // R8 parity errors
    foreach (fr[i]) begin end
    for (int j = 0; j < 4; j++) begin
      logic [7:0] v;
      v = (j == 0) ? 8'h00 : (j == 1) ? 8'hA5 : (j == 2) ? 8'hFF : 8'h01;
      base_v = n_rxv;
      card_send(v, 1'b1, c);
      at_neg(c + 167);
      chk("R8 before nack", line_out, 1);
      at_neg(c + 168);
      chk("R8 nack begins", line_out, 0);
      at_neg(c + 183);
      chk("R8 nack end", line_out, 0);
      at_neg(c + 187);
      chk("R8 nack released", line_out, 1);
      at_neg(c + 192);
      chk("R8 perr flags", {rx_valid, rx_perr}, 2'b01);
      at_neg(c + 200);
      chk("R8 no valid on perr", n_rxv - base_v, 0);
    end

    // R7 glitch rejection then a real character
    base_v = n_rxv; base_p = n_rxp;
    @(negedge clk);
    c = cyc;
    card_n = 1'b0;
    at_neg(c + 3); card_n = 1'b1;
    at_neg(c + 250);
    chk("R7 glitch dropped", (n_rxv - base_v) + (n_rxp - base_p), 0);
    card_send(8'h96, 1'b0, c);
    at_neg(c + 192);
    chk("R7 after glitch", {rx_valid, rx_data}, {1'b1, 8'h96});
    at_neg(c + 200);

    // R9 tick gating: one tick every 3 clocks
    tick_div = 3;
    repeat (4) @(negedge clk);
    send_tx(8'h81, a);
    while (!tx_done && cyc < a + 700) @(negedge clk);
    t = cyc - a;
    chk($sformatf("R9 slowed frame %0d clocks", t), (t >= 573 && t <= 579) ? 1 : 0, 1);
    tick_div = 1;
    repeat (4) @(negedge clk);

    finished = 1;
    report();
  end

endmodule